// File: doc/BRIEF.md
# Two-Stage Load-Balanced Cell Switch

This block is an N-port cell switch that needs no request/grant arbiter. A single crossbar is driven by a fixed, cyclic connection pattern. In slot t, transmitter i is wired to receiver (i + t) mod N, and the slot counter wraps every N cycles. Every port therefore reaches every other port exactly once per period.

Each cell makes two trips through this one crossbar:

- **Spreading trip.** The cell leaves its ingress port towards whichever port the current slot offers. This port is the intermediate, and it is chosen without regard to the cell's destination.
- **Delivery trip.** The intermediate parks the cell in a small per-destination queue. The cell leaves once the rotating pattern links the intermediate to the cell's destination.

When the intermediate already is the destination, the cell goes straight to that port's output.

The ingress side of each port is valid/ready. A source raises `in_valid` with a destination and payload and must hold all three until it sees `in_ready` high at a clock edge. `in_ready` may depend on the presented destination, because acceptance depends on room in the intermediate's queue for that destination. The egress side is a plain registered valid strobe that carries one cell per port per cycle. Cells of one flow may leave out of order; the block does not restore order.

Top module: `lb_cell_switch`

## Requirements
- R1: A slot counter starts at 0 after reset, advances every cycle and wraps from N-1 to 0. In slot t, transmitter i is linked to receiver (i + t) mod N, so each slot is a permutation.
- R2: A cell accepted at port i in slot t crosses to intermediate (i + t) mod N, whatever its destination. With all queues empty, `in_ready` is high.
- R3: A cell held at intermediate m for destination d leaves in the first later slot t' with (m + t') mod N = d. It appears on `out_valid[d]` in the cycle after that slot.
- R4: A cell whose destination equals its intermediate appears on that port's output in the cycle after it is accepted, without queueing.
- R5: Each port keeps one FIFO of VOQ_DEPTH cells per destination. `in_ready` is low whenever the target intermediate's FIFO for the presented destination is full, and no FIFO is ever written while full.
- R6: A queued cell has priority on its link. While intermediate m holds a cell for the receiver the current slot links it to, `in_ready[m]` is low and no new cell enters that link.
- R7: Every accepted cell appears exactly once, at the output of its destination, with its payload unchanged and `out_dest` equal to that port's index.
- R8: During and right after reset, every `out_valid` is low and every `in_ready` is high when no input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_PORTS | Per-port ingress cell valid |
| in_dest | input | N_PORTS*IW | Per-port destination index, IW bits each, port p at [p*IW +: IW] |
| in_data | input | N_PORTS*PAY_W | Per-port payload, port p at [p*PAY_W +: PAY_W] |
| in_ready | output | N_PORTS | Per-port ingress accept |
| out_valid | output | N_PORTS | Per-port egress cell strobe (registered) |
| out_dest | output | N_PORTS*IW | Destination field of the egress cell |
| out_data | output | N_PORTS*PAY_W | Payload of the egress cell |

## Verification
A direct cell lands on its output one cycle after the accepting edge. A queued cell lands one cycle after the first later edge whose slot links its intermediate to its destination. The bench therefore counts accepting edges itself and derives the intermediate and the due edge from that count by modular arithmetic. For every ingress port, destination and starting slot, a lone cell is released and its arrival edge is compared against the computed one. The `in_ready` samples for the priority rule are taken after inputs settle, just before the edge on which the queued cell is due to leave. Random and hot-spot traffic then confirm that each accepted cell arrives exactly once, with a fixed drain interval long enough to empty every queue.

// File: rtl/lb_pkg.sv
package lb_pkg;
  // what a crossbar link carries in one slot
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_SPREAD  = 2'd1,
    LK_DELIVER = 2'd2
  } link_kind_e;
endpackage

// File: rtl/lb_fifo.sv
module lb_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R5
endmodule

// File: rtl/lb_slot_sched.sv
module lb_slot_sched #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [IW-1:0] tgt_of [N],
  output logic [IW-1:0] src_of [N]
);
  logic [IW-1:0] slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   slot <= '0;
    else if (slot == IW'(N - 1))  slot <= '0;
    else                          slot <= slot + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_map
    always_comb begin
      tgt_of[i] = IW'((i + int'(slot)) % N);
      src_of[i] = IW'((i + N - int'(slot)) % N);
    end
    AST_SRC_INVERTS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_of[src_of[i]] == IW'(i)); // R1
  end

  logic [N-1:0] hit;
  always_comb begin
    hit = '0;
    for (int i = 0; i < N; i++) hit[tgt_of[i]] = 1'b1;
  end

  AST_ONE_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == N); // R1
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == IW'(N - 1)) |=> (slot == '0)); // R1
endmodule

// File: rtl/lb_port.sv
module lb_port
  import lb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IW    = 2,
  parameter int PW    = 16,
  parameter int DEPTH = 4,
  parameter int SELF  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] my_tgt,
  input  logic [N-1:0]  tgt_full,
  input  logic          in_valid,
  input  logic [IW-1:0] in_dest,
  input  logic [PW-1:0] in_data,
  output logic          in_ready,
  output link_kind_e    lk_out_kind,
  output logic [IW-1:0] lk_out_dest,
  output logic [PW-1:0] lk_out_data,
  input  link_kind_e    lk_in_kind,
  input  logic [IW-1:0] lk_in_dest,
  input  logic [PW-1:0] lk_in_data,
  output logic [N-1:0]  q_full,
  output logic          out_valid,
  output logic [IW-1:0] out_dest,
  output logic [PW-1:0] out_data
);
  logic [N-1:0]  push, pop, empty_v;
  logic [PW-1:0] head [N];

  for (genvar d = 0; d < N; d++) begin : g_voq
    assign push[d] = (lk_in_kind == LK_SPREAD) && (lk_in_dest == IW'(d)) && (d != SELF);
    assign pop[d]  = !empty_v[d] && (my_tgt == IW'(d));
    lb_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[d]),
      .din   (lk_in_data),
      .pop   (pop[d]),
      .dout  (head[d]),
      .empty (empty_v[d]),
      .full  (q_full[d])
    );
  end

  // transmit side: a held cell for this slot's receiver wins the link
  logic s2_pend, fits;
  always_comb begin
    s2_pend  = !empty_v[my_tgt];
    fits     = (in_dest == my_tgt) || !tgt_full[in_dest];
    in_ready = !s2_pend && fits;
    if (s2_pend) begin
      lk_out_kind = LK_DELIVER;
      lk_out_dest = my_tgt;
      lk_out_data = head[my_tgt];
    end else begin
      lk_out_kind = (in_valid && fits) ? LK_SPREAD : LK_IDLE;
      lk_out_dest = in_dest;
      lk_out_data = in_data;
    end
  end

  // receive side: delivered cells and self-addressed spread cells leave here
  logic to_out;
  assign to_out = (lk_in_kind == LK_DELIVER) ||
                  ((lk_in_kind == LK_SPREAD) && (lk_in_dest == IW'(SELF)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dest  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= to_out;
      if (to_out) begin
        out_dest <= lk_in_dest;
        out_data <= lk_in_data;
      end
    end
  end

  AST_DELIVER_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_in_kind == LK_DELIVER) |-> (lk_in_dest == IW'(SELF))); // R3
  AST_DIRECT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_in_kind == LK_SPREAD) && (lk_in_dest == IW'(SELF))) |=> (out_valid && out_dest == IW'(SELF))); // R4
  AST_SPREAD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_in_kind == LK_SPREAD) && (lk_in_dest != IW'(SELF))) |-> !q_full[lk_in_dest]); // R5
endmodule

// File: rtl/lb_cell_switch.sv
module lb_cell_switch
  import lb_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int PAY_W     = 16,
  parameter int VOQ_DEPTH = 4,
  localparam int IW       = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PORTS-1:0]      in_valid,
  input  logic [N_PORTS*IW-1:0]   in_dest,
  input  logic [N_PORTS*PAY_W-1:0] in_data,
  output logic [N_PORTS-1:0]      in_ready,
  output logic [N_PORTS-1:0]      out_valid,
  output logic [N_PORTS*IW-1:0]   out_dest,
  output logic [N_PORTS*PAY_W-1:0] out_data
);
  logic [IW-1:0]      tgt_of [N_PORTS];
  logic [IW-1:0]      src_of [N_PORTS];
  link_kind_e         tx_kind [N_PORTS];
  logic [IW-1:0]      tx_dest [N_PORTS];
  logic [PAY_W-1:0]   tx_data [N_PORTS];
  link_kind_e         rx_kind [N_PORTS];
  logic [IW-1:0]      rx_dest [N_PORTS];
  logic [PAY_W-1:0]   rx_data [N_PORTS];
  logic [N_PORTS-1:0] qfull  [N_PORTS];
  logic [N_PORTS-1:0] tfull  [N_PORTS];

  lb_slot_sched #(.N(N_PORTS), .IW(IW)) u_sched (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgt_of (tgt_of),
    .src_of (src_of)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign rx_kind[p] = tx_kind[src_of[p]];
    assign rx_dest[p] = tx_dest[src_of[p]];
    assign rx_data[p] = tx_data[src_of[p]];
    assign tfull[p]   = qfull[tgt_of[p]];

    lb_port #(
      .N(N_PORTS), .IW(IW), .PW(PAY_W), .DEPTH(VOQ_DEPTH), .SELF(p)
    ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .my_tgt      (tgt_of[p]),
      .tgt_full    (tfull[p]),
      .in_valid    (in_valid[p]),
      .in_dest     (in_dest[p*IW +: IW]),
      .in_data     (in_data[p*PAY_W +: PAY_W]),
      .in_ready    (in_ready[p]),
      .lk_out_kind (tx_kind[p]),
      .lk_out_dest (tx_dest[p]),
      .lk_out_data (tx_data[p]),
      .lk_in_kind  (rx_kind[p]),
      .lk_in_dest  (rx_dest[p]),
      .lk_in_data  (rx_data[p]),
      .q_full      (qfull[p]),
      .out_valid   (out_valid[p]),
      .out_dest    (out_dest[p*IW +: IW]),
      .out_data    (out_data[p*PAY_W +: PAY_W])
    );

    AST_ACCEPT_CROSSES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[p] && in_ready[p]) |->
        (rx_kind[tgt_of[p]] == LK_SPREAD && rx_data[tgt_of[p]] == in_data[p*PAY_W +: PAY_W])); // R2
  end
endmodule

// File: tb/lb_cell_switch_tb_top.sv
module lb_cell_switch_tb_top;
  localparam int N = 4, IW = 2, PW = 16, DEPTH = 2, MAXID = 8192;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    in_valid;
  logic [N*IW-1:0] in_dest;
  logic [N*PW-1:0] in_data;
  logic [N-1:0]    in_ready, out_valid;
  logic [N*IW-1:0] out_dest;
  logic [N*PW-1:0] out_data;

  lb_cell_switch #(.N_PORTS(N), .PAY_W(PW), .VOQ_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_dest(out_dest), .out_data(out_data)
  );

  int checks = 0, fails = 0, ecount = 0, next_id = 0;
  int probe_id = -1, probe_arr = -1;
  int exp_dest [MAXID];
  bit seen [MAXID];
  bit acc [MAXID];
  bit done = 1'b0;

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input bit v, input int d, input int data);
    in_valid[p]          = v;
    in_dest[p*IW +: IW]  = IW'(d);
    in_data[p*PW +: PW]  = PW'(data);
  endtask

  // egress monitor: R7 exactly-once, right port, right fields
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int p = 0; p < N; p++) begin
        if (out_valid[p]) begin
          int id;
          id = int'(out_data[p*PW +: PW]);
          chk(int'(out_dest[p*IW +: IW]) == p, "R7 out_dest field", int'(out_dest[p*IW +: IW]), p);
          if (id >= next_id) chk(1'b0, "R7 unknown cell id", id, next_id);
          else begin
            chk(exp_dest[id] == p, "R7 arrival port", p, exp_dest[id]);
            chk(!seen[id], "R7 duplicate arrival", int'(seen[id]), 0);
            seen[id] = 1'b1;
            if (id == probe_id) probe_arr = ecount;
          end
        end
      end
    end
  end

  task automatic stress(input bit hot, input int cycles);
    bit pend [N];
    int low, missing;
    low = 0;
    for (int p = 0; p < N; p++) pend[p] = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      for (int p = 0; p < N; p++) begin
        if (!pend[p]) begin
          in_valid[p] = 1'b0;
          if ($urandom_range(3) != 0 && next_id < MAXID - 8) begin
            int d;
            d = hot ? 0 : int'($urandom_range(N - 1));
            exp_dest[next_id] = d;
            drive(p, 1'b1, d, next_id);
            next_id++;
            pend[p] = 1'b1;
          end
        end
      end
      #1;
      for (int p = 0; p < N; p++) begin
        if (pend[p]) begin
          if (in_ready[p]) begin
            acc[int'(in_data[p*PW +: PW])] = 1'b1;
            pend[p] = 1'b0;
          end else low++;
        end
      end
    end
    @(negedge clk);
    in_valid = '0;
    repeat (60) @(negedge clk);
    missing = 0;
    for (int id = 0; id < next_id; id++) if (acc[id] && !seen[id]) missing++;
    chk(missing == 0, hot ? "R7 hot-spot cells lost" : "R7 uniform cells lost", missing, 0);
    if (hot) chk(low > 0, "R5 back-pressure under hot-spot", low, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", ecount, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int id = 0; id < MAXID; id++) begin
      exp_dest[id] = -1; seen[id] = 1'b0; acc[id] = 1'b0;
    end
    rst_n = 1'b0; in_valid = '0; in_dest = '0; in_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == '0, "R8 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == '1, "R8 in_ready in reset", int'(in_ready), 15);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == '0, "R8 out_valid after reset", int'(out_valid), 0);

    // lone-cell sweep: every ingress, destination and starting slot (R1..R4, R6)
    for (int i = 0; i < N; i++) begin
      for (int d = 0; d < N; d++) begin
        for (int ts = 0; ts < N; ts++) begin
          int k, m, kk, exp_arr;
          while ((ecount % N) != ts) @(negedge clk);
          probe_id = next_id; probe_arr = -1;
          exp_dest[next_id] = d; acc[next_id] = 1'b1;
          drive(i, 1'b1, d, next_id);
          next_id++;
          #1;
          chk(in_ready[i], "R2 ready with empty queues", int'(in_ready[i]), 1);
          k = ecount;
          m = (i + k) % N;
          @(negedge clk);
          in_valid[i] = 1'b0;
          if (d == m) exp_arr = k + 1;
          else begin
            kk = k + 1;
            while (((m + kk) % N) != d) kk++;
            exp_arr = kk + 1;
            while (ecount < kk) @(negedge clk);
            drive(m, 1'b1, m, 0);
            #1;
            chk(!in_ready[m], "R6 held cell blocks ingress", int'(in_ready[m]), 0);
            @(negedge clk);
            in_valid[m] = 1'b0;
          end
          while (ecount < exp_arr + 1) @(negedge clk);
          #1;
          if (d == m) chk(probe_arr == exp_arr, "R4 R1 direct arrival edge", probe_arr, exp_arr);
          else        chk(probe_arr == exp_arr, "R3 R1 delivery arrival edge", probe_arr, exp_arr);
        end
      end
    end

    stress(1'b0, 500);
    stress(1'b1, 500);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule